// File: doc/BRIEF.md
# Audio Transmitter Host Control and Flag Unit

This unit is the host-side register block of a serial digital-audio transmitter. A small parallel bus, made of a 2-bit address, 8-bit write data, write and read strobes and registered read data, reaches one read-only status register and two control registers. The second control register drives the datapath controls as plain levels. These are the master-clock ratio code, the validity bit, the buffer-mode code, the channel-status CRC enable, the output-driver enable, and a mute that zeroes the outgoing sample.

A frame counter steps once per frame strobe through a 192-frame block of channel-status data, which is 24 bytes at 8 frames per byte. Three flags are decoded from the counter. The head flag marks the first four channel-status bytes. The half flag marks the second half of the block. The tail flag marks the last two user-data bytes. Each flag is ANDed with its own mask bit, and the results are ORed into one active-high interrupt. The host can force the counter back to the start of a block at any time. While the run bit is clear, the counter is held at zero.

Top module: `audio_tx_ctrl`

## Requirements
- R1: After reset every register is 0. So `rdata` is 0, `irq` is 0, `drv_en` is 0, all control outputs are 0, and `sample_out` is 0 because the sample is muted.
- R2: A read with `rd_en` high returns its data on `rdata` in the next cycle, and `rdata` holds its value while `rd_en` is low. Address 0 is the status register, which returns {5'b0, head, half, tail} (head is bit 2, half is bit 1, tail is bit 0). Writes to address 0 change nothing.
- R3: While control-2 bit 0 (run) is 1, the frame counter advances by one on each cycle with `frame_stb` high and wraps from 191 to 0. While run is 0, the counter is held at 0.
- R4: The head flag (status bit 2) is 1 exactly when the frame counter is 0 to 31.
- R5: The half flag (status bit 1) is 1 exactly when the frame counter is 96 to 191.
- R6: The tail flag (status bit 0) is 1 exactly when the frame counter is 176 to 191.
- R7: A write to address 1 with bit 7 set puts the counter at 0 in the next cycle. This takes priority over a `frame_stb` in the same cycle. Bit 7 reads back as 0.
- R8: Address 1 bits 2:0 are the masks for head, half and tail, in that order, and read back together with bits 7:3 as 0. `irq` is 1 exactly when some flag is 1 and its mask bit is 1.
- R9: Address 2 reads back all 8 bits as written. Bits 7:6 drive `clk_ratio` (00=128x, 01=192x, 10=256x, 11=384x the word rate). Bit 5 drives `validity`, bits 4:3 drive `buf_mode`, and bit 2 drives `crc_en`.
- R10: Control-2 bit 1 (unmute) set to 0 forces `sample_out` to 0. Set to 1, it passes `sample_in` through unchanged in the same cycle.
- R11: `drv_en` equals control-2 bit 0 (run).
- R12: Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| frame_stb | input | 1 | One-cycle pulse per transmitted frame |
| sample_in | input | SW | Audio sample from the datapath |
| sample_out | output | SW | Sample after muting |
| irq | output | 1 | Masked flag interrupt, active high |
| drv_en | output | 1 | Output driver enable |
| clk_ratio | output | 2 | Master-clock ratio code |
| validity | output | 1 | Validity bit for the current sample |
| buf_mode | output | 2 | Buffer-mode code |
| crc_en | output | 1 | Channel-status CRC enable |

## Verification
The frame counter is driven with sparse strobes, dense strobes and back-to-back strobes across more than one full block. Status reads taken along the way show whether each flag window starts and ends on the right frame, and whether the counter wraps at 191. Block-start writes are issued mid-block, and one coincides with a strobe, which shows whether the realignment takes priority. The run bit is cleared mid-block, which shows whether the counter holds at zero and then resumes from zero. Each single mask and the full mask are applied while the counter sweeps all three windows, and control-2 patterns with the mute bit both set and clear are compared against a changing sample, which shows each field driving its own output.

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl #(
  parameter int SW = 24,
  parameter int FRAMES = 192,
  parameter int FPB = 8,
  parameter int HEAD_BYTES = 4,
  parameter int TAIL_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  input  logic          frame_stb,
  input  logic [SW-1:0] sample_in,
  output logic [SW-1:0] sample_out,
  output logic          irq,
  output logic          drv_en,
  output logic [1:0]    clk_ratio,
  output logic          validity,
  output logic [1:0]    buf_mode,
  output logic          crc_en
);
  localparam int CW = $clog2(FRAMES);
  localparam int HEAD_END = HEAD_BYTES * FPB;
  localparam int HALF_START = FRAMES / 2;
  localparam int TAIL_START = FRAMES - TAIL_BYTES * FPB;

  logic [CW-1:0] frame_cnt;
  logic [2:0]    mask;
  logic [7:0]    ctl2;
  logic [2:0]    flags;
  logic [7:0]    rd_mux;

  wire wr_c1 = wr_en && (addr == 2'd1);
  wire wr_c2 = wr_en && (addr == 2'd2);

  assign flags[2] = frame_cnt < CW'(HEAD_END);
  assign flags[1] = frame_cnt >= CW'(HALF_START);
  assign flags[0] = frame_cnt >= CW'(TAIL_START);

  always_comb begin
    case (addr)
      2'd0:    rd_mux = {5'b0, flags};
      2'd1:    rd_mux = {5'b0, mask};
      2'd2:    rd_mux = ctl2;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_cnt <= '0;
      mask      <= '0;
      ctl2      <= '0;
      rdata     <= '0;
    end else begin
      if (wr_c1) mask <= wdata[2:0];
      if (wr_c2) ctl2 <= wdata;
      if (!ctl2[0])
        frame_cnt <= '0;
      else if (wr_c1 && wdata[7])
        frame_cnt <= '0;
      else if (frame_stb)
        frame_cnt <= (frame_cnt == CW'(FRAMES - 1)) ? '0 : frame_cnt + CW'(1);
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign irq        = |(flags & mask);
  assign clk_ratio  = ctl2[7:6];
  assign validity   = ctl2[5];
  assign buf_mode   = ctl2[4:3];
  assign crc_en     = ctl2[2];
  assign sample_out = ctl2[1] ? sample_in : '0;
  assign drv_en     = ctl2[0];
endmodule

// File: rtl/audio_tx_ctrl_chk.sv
module audio_tx_ctrl_chk #(
  parameter int SW = 24,
  parameter int FRAMES = 192,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    addr,
  input logic [7:0]    wdata,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rdata,
  input logic          frame_stb,
  input logic [SW-1:0] sample_out,
  input logic          drv_en,
  input logic [7:0]    ctl2,
  input logic [CW-1:0] frame_cnt
);
  a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt < CW'(FRAMES));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> frame_cnt == '0);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && frame_stb && frame_cnt == CW'(FRAMES - 1) && !(wr_en && addr == 2'd1))
    |=> frame_cnt == '0);

  a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && wdata[7]) |=> frame_cnt == '0);

  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  a_r10_mute: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl2[1] |-> sample_out == '0);
endmodule

bind audio_tx_ctrl audio_tx_ctrl_chk #(.SW(SW), .FRAMES(FRAMES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .frame_stb(frame_stb), .sample_out(sample_out),
  .drv_en(drv_en), .ctl2(ctl2), .frame_cnt(frame_cnt)
);

// File: tb/test_audio_tx_ctrl.sv
module test_audio_tx_ctrl;
  localparam int SW = 24;
  localparam time TCLK = 10ns;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [1:0]    addr = 0;
  logic [7:0]    wdata = 0;
  logic          wr_en = 0, rd_en = 0, frame_stb = 0;
  logic [SW-1:0] sample_in = 0;
  logic [SW-1:0] sample_out;
  logic [7:0]    rdata;
  logic          irq, drv_en, validity, crc_en;
  logic [1:0]    clk_ratio, buf_mode;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_cnt = 0, m_mask = 0, m_c2 = 0, m_rd = 0;
  int unsigned lfsr = 32'h1ace_b00c;

  audio_tx_ctrl #(.SW(SW)) i_audio_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .frame_stb(frame_stb), .sample_in(sample_in),
    .sample_out(sample_out), .irq(irq), .drv_en(drv_en), .clk_ratio(clk_ratio),
    .validity(validity), .buf_mode(buf_mode), .crc_en(crc_en)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic int m_flags(int c);
    // R4 head 0..31, R5 half 96..191, R6 tail 176..191
    return ((c < 32) ? 4 : 0) | ((c >= 96) ? 2 : 0) | ((c >= 176) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mask = 0; m_c2 = 0; m_rd = 0;
    end else begin
      int nrd, ncnt;
      nrd = m_rd;
      if (rd_en)
        case (addr)
          2'd0: nrd = m_flags(m_cnt);
          2'd1: nrd = m_mask;
          2'd2: nrd = m_c2;
          default: nrd = 0;
        endcase
      ncnt = m_cnt;
      if ((m_c2 & 1) == 0) ncnt = 0;
      else if (wr_en && addr == 2'd1 && wdata[7]) ncnt = 0;
      else if (frame_stb) ncnt = (m_cnt + 1) % 192;
      if (wr_en && addr == 2'd1) m_mask = wdata & 7;
      if (wr_en && addr == 2'd2) m_c2 = wdata;
      m_cnt = ncnt;
      m_rd = nrd;
    end
  end

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R2 rdata (R4 R5 R6 R7 R9 R12 readback)", rdata, m_rd);
    check("R8 irq", irq, (m_flags(m_cnt) & m_mask) != 0);
    check("R10 sample_out", sample_out, ((m_c2 >> 1) & 1) ? sample_in : 0);
    check("R11 drv_en", drv_en, m_c2 & 1);
    check("R9 clk_ratio", clk_ratio, (m_c2 >> 6) & 3);
    check("R9 validity", validity, (m_c2 >> 5) & 1);
    check("R9 buf_mode", buf_mode, (m_c2 >> 3) & 3);
    check("R9 crc_en", crc_en, (m_c2 >> 2) & 1);
  endtask

  task automatic step(bit w, bit r, logic [1:0] a, logic [7:0] d, bit fs);
    @(negedge clk);
    compare();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h8020_0003 : 0);
    wr_en = w; rd_en = r; addr = a; wdata = d; frame_stb = fs;
    sample_in = lfsr[SW-1:0];
  endtask

  task automatic run(int n, int gap, logic [1:0] a);
    for (int i = 0; i < n; i++) step(0, 1, a, 0, (i % gap) == 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 0);
    check("R1 irq", irq, 0);
    check("R1 drv_en", drv_en, 0);
    check("R1 sample_out", sample_out, 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) step(0, 1, 2'(a), 0, 1);
    step(1, 0, 2'd2, 8'h03, 0);                 // run, unmuted
    step(1, 0, 2'd1, 8'h07, 0);                 // all masks
    run(420, 1, 2'd0);                          // R3 dense strobes, wrap
    run(300, 3, 2'd0);                          // sparse strobes
    step(1, 0, 2'd1, 8'h81, 1);                 // R7 realign with strobe
    run(60, 1, 2'd0);
    step(0, 1, 2'd1, 0, 0);                     // R7 bit 7 reads 0
    step(1, 0, 2'd1, 8'h02, 0);
    run(200, 2, 2'd0);
    step(1, 0, 2'd1, 8'h04, 0);
    run(200, 1, 2'd0);
    step(1, 0, 2'd1, 8'h01, 0);
    run(200, 1, 2'd0);
    step(1, 0, 2'd0, 8'hff, 1);                 // R2 status write ignored
    step(1, 0, 2'd3, 8'hff, 1);                 // R12
    for (int a = 0; a < 4; a++) step(0, 1, 2'(a), 0, 1);
    step(1, 0, 2'd2, 8'hfc, 1);                 // R3 run cleared, muted
    run(50, 1, 2'd0);
    step(1, 0, 2'd2, 8'h5b, 0);                 // R9 pattern, run, unmuted
    run(100, 1, 2'd2);
    step(1, 0, 2'd2, 8'ha5, 1);                 // run, muted
    run(250, 1, 2'd0);
    step(1, 0, 2'd1, 8'h87, 1);
    for (int i = 0; i < 600; i++) step(0, lfsr[3], 2'(lfsr[5:4]), 0, lfsr[0]);
    step(1, 0, 2'd2, 8'h00, 0);
    run(20, 1, 2'd0);
    step(0, 0, 2'd0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule